// File: doc/BRIEF.md
# Twisted-Ring Serial Pattern Generator

The block plays a repeating six-bit serial pattern. A three-bit twisted-ring counter has six legal states. It advances one state per clock, and its current value selects one bit of an eight-bit pattern bus. The selected bit is registered onto a single serial output. Software or neighbouring logic sets the pattern by holding a value on the bus. The output then repeats that value's bits in the fixed order in which the counter visits its codes.

The counter visits codes 0, 1, 3, 7, 6 and 4. The output is therefore a permutation of part of the bus, not a plain shift of it. Bus bits 2 and 5 are never selected. The current counter value is also brought out so that a consumer can align to the pattern.

Top module: `twisted_ring_seqgen`

## Requirements
- R1: After reset is released, `ring_o` takes the values 000, 001, 011, 111, 110, 100 on successive clock edges and then repeats from 000.
- R2: While `rst` is high at a rising edge, that edge sets `ring_o` to 000 and `serial_o` to 0, whatever the state or pattern was.
- R3: Each step of the counter outside reset shifts it toward the higher bit and loads the inverse of the old top bit into bit 0, so exactly one bit of `ring_o` changes per step.
- R4: Codes 010 and 101 never appear on `ring_o`. If the counter ever holds either code, the next edge puts it at 000.
- R5: At each rising edge outside reset, `serial_o` takes `pattern_i[k]`, where k is the value `ring_o` held just before that edge. The output lags the counter by one clock.
- R6: Over one period after reset, `serial_o` gives `pattern_i` bits 0, 1, 3, 7, 6, 4 in that order. For example, `pattern_i` = 8'h8B yields 1,1,1,1,0,0 repeating.
- R7: Bits 2 and 5 of `pattern_i` have no effect on `serial_o`.
- R8: A change on `pattern_i` during a period shows on `serial_o` at the very next edge, in the slot whose code selects the changed bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pattern_i | input | 8 | Pattern bus; bit k is played when the counter holds code k |
| serial_o | output | 1 | Registered serial pattern bit |
| ring_o | output | 3 | Current twisted-ring counter value |

## Verification
The bench plays several patterns. These include single-bit patterns, all-zero and all-one patterns, and a pattern that sets only the two unselected bits. A design that used a plain binary count, or that fed back the top bit without inverting it, would emit the bits in the wrong slots or stall. Sampling one slot early or late would show up as a rotated pattern. A mid-period pattern change exposes any extra pipeline stage on the bus. Resetting mid-run with an all-one pattern catches a reset that clears the counter but leaves a stale output bit.

// File: rtl/jsg_pkg.sv
package jsg_pkg;
  localparam int unsigned RING_W = 3;
  localparam int unsigned PAT_W  = 1 << RING_W;

  typedef logic [RING_W-1:0] ring_t;

  // shift up, inverted top bit enters at bit 0
  function automatic ring_t ring_step(input ring_t s);
    return {s[RING_W-2:0], ~s[RING_W-1]};
  endfunction

  // a legal twisted-ring code has at most one boundary between
  // adjacent bits that differ
  function automatic logic ring_legal(input ring_t s);
    int unsigned edges;
    edges = 0;
    for (int i = 0; i < RING_W - 1; i++) begin
      if (s[i] != s[i+1]) edges++;
    end
    return (edges <= 1);
  endfunction
endpackage

// File: rtl/jsg_ring.sv
module jsg_ring
  import jsg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output ring_t state_o,
  output logic  legal_o
);
  ring_t state_q;
  ring_t state_d;
  logic  legal_w;

  assign legal_w = ring_legal(state_q);

  always_comb begin
    if (legal_w) state_d = ring_step(state_q);
    else         state_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= state_d;
  end

  assign state_o = state_q;
  assign legal_o = legal_w;

  // R2: reset lands the counter at zero
  p_reset_zero_r2: assert property (@(posedge clk) rst |=> state_q == '0);
  // R3: a legal step flips exactly one bit
  p_one_bit_step_r3: assert property (@(posedge clk) disable iff (rst)
    legal_w |=> $countones(state_q ^ $past(state_q)) == 1);
  // R4: an illegal code recovers to zero
  p_recover_r4: assert property (@(posedge clk) disable iff (rst)
    !legal_w |=> state_q == '0);
  // R4: the loop of legal codes is closed
  p_stay_legal_r4: assert property (@(posedge clk) disable iff (rst)
    legal_w |=> legal_w);
endmodule

// File: rtl/jsg_pick.sv
module jsg_pick
  import jsg_pkg::*;
(
  input  logic [PAT_W-1:0] data_i,
  input  ring_t            sel_i,
  output logic             bit_o
);
  logic [PAT_W-1:0] hit;

  generate
    for (genvar g = 0; g < PAT_W; g++) begin : g_tap
      assign hit[g] = data_i[g] & (sel_i == ring_t'(g));
    end
  endgenerate

  assign bit_o = |hit;
endmodule

// File: rtl/twisted_ring_seqgen.sv
module twisted_ring_seqgen
  import jsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] pattern_i,
  output logic       serial_o,
  output logic [2:0] ring_o
);
  ring_t state_w;
  logic  legal_w;
  logic  pick_w;
  logic  serial_q;

  jsg_ring u_ring (
    .clk     (clk),
    .rst     (rst),
    .state_o (state_w),
    .legal_o (legal_w)
  );

  jsg_pick u_pick (
    .data_i (pattern_i),
    .sel_i  (state_w),
    .bit_o  (pick_w)
  );

  always_ff @(posedge clk) begin
    if (rst) serial_q <= 1'b0;
    else     serial_q <= pick_w;
  end

  assign serial_o = serial_q;
  assign ring_o   = state_w;

  // R2: reset clears the output bit
  p_reset_out_r2: assert property (@(posedge clk) rst |=> !serial_o);
  // R5: the output carries the selected bit one clock later
  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> serial_o == $past(pick_w));
  // R7: selecting an unused input position never happens on a legal code
  p_unused_sel_r7: assert property (@(posedge clk) disable iff (rst)
    legal_w |-> (ring_o != 3'd2 && ring_o != 3'd5));
endmodule

// File: tb/twisted_ring_seqgen_bench.sv
`timescale 1ns/1ps
module twisted_ring_seqgen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pattern_i = 8'h00;
  logic       serial_o;
  logic [2:0] ring_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  twisted_ring_seqgen u_twisted_ring_seqgen (
    .clk       (clk),
    .rst       (rst),
    .pattern_i (pattern_i),
    .serial_o  (serial_o),
    .ring_o    (ring_o)
  );

  localparam logic [2:0] ORD [6] = '{3'd0, 3'd1, 3'd3, 3'd7, 3'd6, 3'd4};
  localparam int NV = 7;
  localparam logic [7:0] VEC_PAT [NV] =
    '{8'h8B, 8'h00, 8'hFF, 8'h01, 8'h50, 8'h24, 8'h40};
  localparam logic [5:0] VEC_EXP [NV] =
    '{6'b111100, 6'b000000, 6'b111111, 6'b100000, 6'b000011, 6'b000000, 6'b000010};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [2:0] prev;
    @(negedge clk);
    step();
    chk("R2", {7'd0, serial_o}, 8'd0);
    chk("R2", {5'd0, ring_o}, 8'd0);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      pattern_i = VEC_PAT[v];
      rst = 1'b1;
      step();
      step();
      chk("R2", {5'd0, ring_o}, 8'd0);
      rst = 1'b0;
      prev = ring_o;
      for (int k = 1; k <= 12; k++) begin
        step();
        chk("R1", {5'd0, ring_o}, {5'd0, ORD[k % 6]});
        chk("R3", 8'($countones(ring_o ^ prev)), 8'd1);
        chk("R4", {7'd0, (ring_o == 3'd2 || ring_o == 3'd5)}, 8'd0);
        if (v == 5) chk("R7", {7'd0, serial_o}, 8'd0);
        else        chk("R6", {7'd0, serial_o}, {7'd0, VEC_EXP[v][5 - ((k - 1) % 6)]});
        prev = ring_o;
      end
    end

    // R5 / R8: mid-period pattern change lands on the next edge
    pattern_i = 8'h00;
    rst = 1'b1;
    step();
    rst = 1'b0;
    step();
    step();
    chk("R1", {5'd0, ring_o}, 8'd3);
    pattern_i = 8'h08;
    step();
    chk("R8", {7'd0, serial_o}, 8'd1);
    pattern_i = 8'h00;
    step();
    chk("R5", {7'd0, serial_o}, 8'd0);
    pattern_i = 8'h40;
    step();
    chk("R5", {7'd0, serial_o}, 8'd1);

    // R2: reset mid-run with all ones still clears the output
    pattern_i = 8'hFF;
    step();
    chk("R6", {7'd0, serial_o}, 8'd1);
    rst = 1'b1;
    step();
    chk("R2", {7'd0, serial_o}, 8'd0);
    chk("R2", {5'd0, ring_o}, 8'd0);
    rst = 1'b0;
    step();
    chk("R5", {7'd0, serial_o}, 8'd1);

    finish_run();
  end
endmodule